// File: doc/BRIEF.md
# Interrupt Controller with Stack-Pointer Pair Gate

This block collects interrupt events from a set of peripheral sources into per-source pending flags. It keeps a mask bit for each source and raises a level maskable request to the CPU. It also holds a non-maskable request that is captured on a rising edge. Software reads the pending flags through a small register port and clears a flag by writing a one to its bit position. Flags record events even when their mask bit is zero. A request raised by a flag stays asserted for as long as the flag is set. When the CPU drops its global enable and later raises it again (on an enable instruction or a return from interrupt), the same request is presented again.

Every request, the non-maskable one included, also passes through a gate tied to the CPU's two stack pointers. The CPU marks each stack-pointer update with a strobe. After reset the gate is closed, and it opens only once both pointers have been written, in either order or in the same cycle. While the gate is open, a write to either pointer closes it again, and it stays closed until the partner pointer has been written as well. Each time the gate opens, both "written" marks are cleared, so every later rewrite must again come as a pair.

The register port is a plain single-cycle control interface with no handshake. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` follows `bus_addr` combinationally and shows the register state after the most recent edge. No data stream passes through the block, so it has no valid/ready back-pressure.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset all pending flags and mask bits read as zero, the gate is closed, the non-maskable latch is empty, and both request outputs are low.
- R2: A high `src_evt[i]` at a clock edge sets pending flag i, whatever the value of mask bit i. Register address 0 reads the pending flags, with bit i belonging to source i.
- R3: A write to address 0 clears every pending flag whose `bus_wdata` bit is 1 and leaves flags whose data bit is 0 unchanged.
- R4: If an event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R5: `irq_req` is high exactly when the gate is open, `gie` is high, and at least one source has both its pending flag and its mask bit set.
- R6: A pending, unmasked flag keeps its request alive. When `gie` is lowered and then raised again with the flag still set, `irq_req` comes back.
- R7: After reset the gate opens only once both `spa_wr` and `spb_wr` have been seen, in either order or together. A single pointer write, even when repeated, leaves the gate closed.
- R8: While the gate is open, a write to only one stack pointer closes it at the next edge and blocks both requests. The gate reopens at the edge where the other pointer is written.
- R9: A rising edge on `nmi_in` is latched. `nmi_req` shows the latch qualified only by the gate: it ignores `gie` and the masks, an edge seen while the gate is closed is held until the gate opens, and a level held high does not latch again.
- R10: `nmi_ack` empties the non-maskable latch. A new edge in the same cycle as an acknowledge wins, and the latch stays full.
- R11: Address 1 is the mask register. It can be written and read back, with bit i masking source i. Addresses 2 and 3 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | N_SRC | Per-source interrupt event, one bit per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 pending flags, 1 mask) |
| bus_wdata | input | N_SRC | Register write data |
| bus_rdata | output | N_SRC | Register read data for `bus_addr` |
| spa_wr | input | 1 | Write strobe of the first stack pointer |
| spb_wr | input | 1 | Write strobe of the second stack pointer |
| gie | input | 1 | CPU global interrupt enable |
| nmi_in | input | 1 | Non-maskable interrupt line, edge-sensitive |
| nmi_ack | input | 1 | CPU acceptance of the non-maskable request |
| irq_req | output | 1 | Maskable interrupt request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The maskable path is driven with each combination of flag, mask, global enable and gate state. The patterns show whether the request follows the AND of all four or leaks when just one of them is missing. The gate is tested with pointer writes in both orders, with both in one cycle, and with the same pointer written twice. These patterns separate a true pair handshake from a simple "any write" or "last write" scheme. Non-maskable traffic is applied as held levels, as edges coinciding with acknowledges, and as edges that arrive while the gate is closed. They show whether the latch detects edges and not levels, whether set wins over acknowledge, and whether a blocked edge is kept rather than dropped.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_FLAGS = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK  = 2'd1;

  typedef struct packed {
    logic a_seen;
    logic b_seen;
    logic open;
  } gate_state_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             clr_stb,
  input  logic             mask_stb,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] mask,
  output logic             any_unmasked
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (src_evt[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_stb && wdata[i]) begin
        flags[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[i] <= 1'b0;
      end else if (mask_stb) begin
        mask[i] <= wdata[i];
      end
    end

    assign hit[i] = flags[i] & mask[i];
  end

  assign any_unmasked = |hit;

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((flags & $past(src_evt)) == $past(src_evt)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((flags & $past(wdata & ~src_evt)) == '0));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stb && src_evt == '0) |=> (flags == $past(flags)));
endmodule

// File: rtl/irq_sp_gate.sv
module irq_sp_gate
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic spa_wr,
  input  logic spb_wr,
  output logic gate_open
);
  gate_state_t st_q, st_d;
  logic a_next, b_next;

  assign a_next = st_q.a_seen | spa_wr;
  assign b_next = st_q.b_seen | spb_wr;

  always_comb begin
    st_d = st_q;
    if (a_next && b_next) begin
      st_d.a_seen = 1'b0;
      st_d.b_seen = 1'b0;
      st_d.open   = 1'b1;
    end else if (spa_wr || spb_wr) begin
      st_d.a_seen = a_next;
      st_d.b_seen = b_next;
      st_d.open   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign gate_open = st_q.open;

  // R7
  open_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> $past(spa_wr || spb_wr));

  // R8
  lone_write_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((spa_wr && !spb_wr && !st_q.b_seen) || (spb_wr && !spa_wr && !st_q.a_seen))
      |=> !gate_open);

  // R7
  pair_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((spa_wr || st_q.a_seen) && (spb_wr || st_q.b_seen)) |=> gate_open);
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic nmi_ack,
  output logic pending
);
  logic nmi_prev;
  logic edge_seen;

  assign edge_seen = nmi_in & ~nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      pending  <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (edge_seen) begin
        pending <= 1'b1;
      end else if (nmi_ack) begin
        pending <= 1'b0;
      end
    end
  end

  // R9
  nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> pending);

  // R10
  nmi_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !edge_seen) |=> !pending);

  // R9
  nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !nmi_ack) |=> pending);
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic              spa_wr,
  input  logic              spb_wr,
  input  logic              gie,
  input  logic              nmi_in,
  input  logic              nmi_ack,
  output logic              irq_req,
  output logic              nmi_req
);
  logic [N_SRC-1:0] flags, mask;
  logic any_unmasked, gate_open, nmi_pend;
  logic clr_stb, mask_stb;

  assign clr_stb  = bus_wr && (bus_addr == ADDR_FLAGS);
  assign mask_stb = bus_wr && (bus_addr == ADDR_MASK);

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr_stb(clr_stb),
    .mask_stb(mask_stb), .wdata(bus_wdata), .flags(flags), .mask(mask),
    .any_unmasked(any_unmasked)
  );

  irq_sp_gate u_gate (
    .clk(clk), .rst_n(rst_n), .spa_wr(spa_wr), .spb_wr(spb_wr),
    .gate_open(gate_open)
  );

  irq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .nmi_ack(nmi_ack),
    .pending(nmi_pend)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_FLAGS: bus_rdata = flags;
      ADDR_MASK:  bus_rdata = mask;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_req = gate_open & gie & any_unmasked;
  assign nmi_req = gate_open & nmi_pend;

  // R5
  irq_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gate_open && gie && ((flags & mask) != '0)));

  // R9
  nmi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> gate_open);

  // R8
  lone_write_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && (spa_wr ^ spb_wr)) |=> (!irq_req && !nmi_req));
endmodule

// File: tb/irq_gate_ctrl_tb.sv
module irq_gate_ctrl_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic spa_wr = 1'b0, spb_wr = 1'b0, gie = 1'b0, nmi_in = 1'b0, nmi_ack = 1'b0;
  logic irq_req, nmi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_gate_ctrl #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spa_wr(spa_wr), .spb_wr(spb_wr), .gie(gie), .nmi_in(nmi_in),
    .nmi_ack(nmi_ack), .irq_req(irq_req), .nmi_req(nmi_req)
  );

  typedef struct packed {
    logic       sa;
    logic       sb;
    logic       g;
    logic [7:0] evt;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] wd;
    logic       nmi;
    logic       ack;
    logic       e_irq;
    logic       e_nmi;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 25;
  // fields: sa sb gie evt wr addr wdata nmi ack | exp irq, exp nmi, exp rdata
  localparam vec_t VEC [NV] = '{
    '{0,0,0,8'h00,0,2'd0,8'h00,0,0, 0,0,8'h00}, // 0  R1 idle
    '{0,0,0,8'h01,0,2'd0,8'h00,0,0, 0,0,8'h01}, // 1  R2 flag set, mask 0
    '{0,0,1,8'h00,1,2'd1,8'h01,0,0, 0,0,8'h01}, // 2  R11 R7 mask, gate closed
    '{1,0,1,8'h00,0,2'd1,8'h00,0,0, 0,0,8'h01}, // 3  R7 only A
    '{0,1,1,8'h00,0,2'd1,8'h00,0,0, 1,0,8'h01}, // 4  R7 B completes
    '{0,0,0,8'h00,0,2'd0,8'h00,0,0, 0,0,8'h01}, // 5  R5 gie low
    '{0,0,1,8'h00,0,2'd0,8'h00,0,0, 1,0,8'h01}, // 6  R6 re-enabled
    '{0,0,1,8'h00,1,2'd0,8'h00,0,0, 1,0,8'h01}, // 7  R3 write 0 keeps
    '{0,0,1,8'h00,1,2'd0,8'h01,0,0, 0,0,8'h00}, // 8  R3 write 1 clears
    '{0,0,1,8'h02,0,2'd0,8'h00,0,0, 0,0,8'h02}, // 9  R5 masked source
    '{0,0,1,8'h00,1,2'd1,8'h03,0,0, 1,0,8'h03}, // 10 R11 R5 unmask
    '{0,0,1,8'h02,1,2'd0,8'h02,0,0, 1,0,8'h02}, // 11 R4 set wins
    '{0,0,1,8'h00,1,2'd0,8'h02,0,0, 0,0,8'h00}, // 12 R3 clear
    '{0,0,0,8'h00,0,2'd0,8'h00,1,0, 0,1,8'h00}, // 13 R9 edge, gie ignored
    '{0,0,0,8'h00,0,2'd0,8'h00,1,1, 0,0,8'h00}, // 14 R10 ack
    '{0,0,0,8'h00,0,2'd0,8'h00,1,0, 0,0,8'h00}, // 15 R9 held level
    '{0,0,0,8'h00,0,2'd0,8'h00,0,0, 0,0,8'h00}, // 16
    '{0,0,0,8'h00,0,2'd0,8'h00,1,1, 0,1,8'h00}, // 17 R10 edge beats ack
    '{0,0,0,8'h00,0,2'd0,8'h00,1,1, 0,0,8'h00}, // 18 R10 ack
    '{0,0,1,8'h01,0,2'd0,8'h00,0,0, 1,0,8'h01}, // 19 R5
    '{1,0,1,8'h00,0,2'd0,8'h00,0,0, 0,0,8'h01}, // 20 R8 lone A closes
    '{1,0,1,8'h00,0,2'd0,8'h00,0,0, 0,0,8'h01}, // 21 R8 A again
    '{0,0,1,8'h00,0,2'd0,8'h00,1,0, 0,0,8'h01}, // 22 R9 edge while closed
    '{0,1,1,8'h00,0,2'd0,8'h00,1,0, 1,1,8'h01}, // 23 R8 R9 partner opens
    '{0,0,0,8'h00,0,2'd0,8'h00,1,1, 0,0,8'h01}  // 24 R10 ack
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    src_evt = '0; bus_wr = 0; bus_wdata = '0; spa_wr = 0; spb_wr = 0; nmi_ack = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    gie = 0; nmi_in = 0; bus_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    #1;
    check("R1 irq", irq_req, 0);
    check("R1 nmi", nmi_req, 0);
    check("R1 flags", bus_rdata, 0);
    bus_addr = 2'd1; #1;
    check("R1 mask", bus_rdata, 0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      spa_wr = VEC[k].sa; spb_wr = VEC[k].sb; gie = VEC[k].g;
      src_evt = VEC[k].evt; bus_wr = VEC[k].wr; bus_addr = VEC[k].addr;
      bus_wdata = VEC[k].wd; nmi_in = VEC[k].nmi; nmi_ack = VEC[k].ack;
      step();
      check($sformatf("vec%0d irq", k), irq_req, VEC[k].e_irq);
      check($sformatf("vec%0d nmi", k), nmi_req, VEC[k].e_nmi);
      check($sformatf("vec%0d rdata", k), bus_rdata, VEC[k].e_rd);
    end

    // R1 reset mid-run clears everything
    do_reset();
    #1;
    check("R1 after rerun irq", irq_req, 0);
    check("R1 after rerun flags", bus_rdata, 0);

    // R7 both pointers in one cycle open the gate
    @(negedge clk);
    spa_wr = 1; spb_wr = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h80;
    src_evt = 8'h80; gie = 1;
    step();
    check("R7 same-cycle pair opens", irq_req, 1);

    // R7 reverse order after reset: B then A
    do_reset();
    @(negedge clk);
    bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h10; src_evt = 8'h10; gie = 1;
    spb_wr = 1;
    step();
    check("R7 B alone keeps closed", irq_req, 0);
    @(negedge clk);
    idle_inputs(); spb_wr = 1;
    step();
    check("R7 B twice keeps closed", irq_req, 0);
    @(negedge clk);
    idle_inputs(); spa_wr = 1;
    step();
    check("R7 A after B opens", irq_req, 1);

    // R11 unused addresses read zero and ignore writes
    @(negedge clk);
    idle_inputs(); bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'hFF;
    step();
    check("R11 addr2 reads zero", bus_rdata, 0);
    @(negedge clk);
    idle_inputs(); bus_addr = 2'd1; #1;
    check("R11 mask untouched", bus_rdata, 8'h10);
    bus_addr = 2'd0; #1;
    check("R11 flags untouched", bus_rdata, 8'h10);
    check("R11 request intact", irq_req, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule